// File: doc/BRIEF.md
# Port Group Index Allocator

This block hands out entries of a port-group-mask table to clients and takes them back. The low part of the table is fixed for per-port destination masks, flood masks and CPU forwarding, so it is never handed out. The entries above it form one pool that multicast groups, link aggregation groups and virtualization profiles share. Inside that pool there is a window held back for global aggregation. The generic allocator never hands out any entry in that window.

A client raises a request with a purpose class. One cycle later the block answers in one of two ways: a grant pulse carrying the lowest free allocatable index, or a grant pulse with the full flag set when nothing is left. A client returns an index through the free port. A return of an index that is reserved, held back, out of range or not in use changes nothing and raises an error pulse. Writing the masks into the table is done elsewhere.

Top module: `pgid_alloc`

## Requirements
- R1: After reset, grant_valid, grant_full and free_err are 0, and every allocatable entry is free, so the first grant returns index RSVD_COUNT.
- R2: grant_valid is high in exactly the cycle after a cycle in which req_valid was sampled high, and low otherwise.
- R3: A successful grant returns the lowest-numbered allocatable index that is not in use, and marks that index in use.
- R4: No grant ever returns an index below RSVD_COUNT.
- R5: No grant ever returns an index in the window GAGG_BASE to GAGG_BASE+GAGG_LEN-1.
- R6: When no allocatable entry is free, the grant cycle shows grant_valid=1, grant_full=1 and grant_idx=0. Otherwise grant_full is 0.
- R7: Freeing an allocatable index that is in use releases it, and a later request can receive it again.
- R8: Freeing an index that is reserved, inside the held-back window, at or above TABLE_DEPTH, or not in use leaves the allocation state unchanged and raises free_err for one cycle in the following cycle.
- R9: A request and a free in the same cycle are both honoured. The grant is computed from the state before the free, so the freed entry is available from the next cycle on.
- R10: grant_class repeats the class given with the request: 0 multicast, 1 link aggregation, 2 virtualization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request for one table entry |
| req_class | input | 2 | Purpose class of the request |
| free_valid | input | 1 | Return of one entry |
| free_idx | input | IDX_W | Index being returned |
| grant_valid | output | 1 | Answer pulse for a request |
| grant_full | output | 1 | Request failed, no entry free |
| grant_idx | output | IDX_W | Granted index |
| grant_class | output | 2 | Class of the answered request |
| free_err | output | 1 | Rejected return pulse |

## Verification
The hardest case to reach is the full condition at the moment a free arrives. From the outside, the only way in is to drain the whole pool. The bench therefore uses a small table of 32 entries with 8 reserved and a 4-entry held-back window. It fills all 20 allocatable entries, then issues a request and a free in the same cycle. The request must still report full, and the freed index must come back on the next request. The bench scatters frees across the pool to test that the lowest free index is chosen. It also sweeps every reserved and held-back index through the free port to produce the error pulse.

// File: rtl/pgid_alloc_pkg.sv
package pgid_alloc_pkg;
   typedef enum logic [1:0] {
      PG_CLASS_MCAST = 2'd0,
      PG_CLASS_LAG   = 2'd1,
      PG_CLASS_VIRT  = 2'd2,
      PG_CLASS_RSV   = 2'd3
   } pg_class_e;

   typedef struct packed {
      logic      valid;
      logic      full;
      pg_class_e cls;
   } pg_grant_t;
endpackage

// File: rtl/pgid_alloc_mask.sv
module pgid_alloc_mask #(
   parameter int TABLE_DEPTH = 1024,
   parameter int RSVD_COUNT  = 72,
   parameter int GAGG_BASE   = 512,
   parameter int GAGG_LEN    = 64
) (
   output logic [TABLE_DEPTH-1:0] alloc_ok
);
   localparam int GAGG_END = GAGG_BASE + GAGG_LEN;

   for (genvar gi = 0; gi < TABLE_DEPTH; gi++) begin : g_ent
      if (gi < RSVD_COUNT) begin : g_fixed
         assign alloc_ok[gi] = 1'b0;
      end else if (gi >= GAGG_BASE && gi < GAGG_END) begin : g_held
         assign alloc_ok[gi] = 1'b0;
      end else begin : g_pool
         assign alloc_ok[gi] = 1'b1;
      end
   end
endmodule

// File: rtl/pgid_alloc_prio.sv
module pgid_alloc_prio #(
   parameter int WIDTH = 1024,
   localparam int IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] cand,
   output logic             found,
   output logic [IW-1:0]    first
);
   always_comb begin
      found = 1'b0;
      first = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (cand[i]) begin
            found = 1'b1;
            first = IW'(i);
         end
      end
   end
endmodule

// File: rtl/pgid_alloc_map.sv
module pgid_alloc_map #(
   parameter int TABLE_DEPTH = 1024,
   localparam int IW         = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   set_en,
   input  logic [IW-1:0]          set_idx,
   input  logic                   clr_en,
   input  logic [IW-1:0]          clr_idx,
   output logic [TABLE_DEPTH-1:0] in_use
);
   logic [TABLE_DEPTH-1:0] set_vec;
   logic [TABLE_DEPTH-1:0] clr_vec;

   always_comb begin
      set_vec = '0;
      clr_vec = '0;
      if (set_en) set_vec = TABLE_DEPTH'(1) << set_idx;
      if (clr_en) clr_vec = TABLE_DEPTH'(1) << clr_idx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) in_use <= '0;
      else        in_use <= (in_use | set_vec) & ~clr_vec;
   end
endmodule

// File: rtl/pgid_alloc.sv
module pgid_alloc #(
   parameter int TABLE_DEPTH = 1024,
   parameter int RSVD_COUNT  = 72,
   parameter int GAGG_BASE   = 512,
   parameter int GAGG_LEN    = 64,
   localparam int IDX_W      = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_class,
   input  logic             free_valid,
   input  logic [IDX_W-1:0] free_idx,
   output logic             grant_valid,
   output logic             grant_full,
   output logic [IDX_W-1:0] grant_idx,
   output logic [1:0]       grant_class,
   output logic             free_err
);
   import pgid_alloc_pkg::*;

   if (RSVD_COUNT < 0 || RSVD_COUNT >= TABLE_DEPTH) begin : g_bad_rsvd
      $error("reserved region must leave pool entries");
   end
   if (GAGG_LEN > 0 && (GAGG_BASE < RSVD_COUNT || GAGG_BASE + GAGG_LEN > TABLE_DEPTH)) begin : g_bad_gagg
      $error("held-back window must lie inside the shared pool");
   end

   logic [TABLE_DEPTH-1:0] alloc_ok;
   logic [TABLE_DEPTH-1:0] in_use;
   logic [TABLE_DEPTH-1:0] avail;
   logic                   any_free;
   logic [IDX_W-1:0]       low_idx;
   logic                   take;
   logic                   free_in_rng;
   logic                   free_good;
   pg_grant_t              grant_q;
   logic [IDX_W-1:0]       idx_q;
   logic                   err_q;

   pgid_alloc_mask #(
      .TABLE_DEPTH(TABLE_DEPTH), .RSVD_COUNT(RSVD_COUNT),
      .GAGG_BASE(GAGG_BASE), .GAGG_LEN(GAGG_LEN)
   ) u_mask (
      .alloc_ok(alloc_ok)
   );

   assign avail = alloc_ok & ~in_use;

   pgid_alloc_prio #(.WIDTH(TABLE_DEPTH)) u_prio (
      .cand (avail),
      .found(any_free),
      .first(low_idx)
   );

   assign take        = req_valid && any_free;
   assign free_in_rng = ({1'b0, free_idx} < (IDX_W+1)'(TABLE_DEPTH));

   always_comb begin
      free_good = 1'b0;
      if (free_valid && free_in_rng)
         free_good = alloc_ok[free_idx] && in_use[free_idx];
   end

   pgid_alloc_map #(.TABLE_DEPTH(TABLE_DEPTH)) u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (take),
      .set_idx(low_idx),
      .clr_en (free_good),
      .clr_idx(free_idx),
      .in_use (in_use)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q <= '{valid: 1'b0, full: 1'b0, cls: PG_CLASS_MCAST};
         idx_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         grant_q.valid <= req_valid;
         grant_q.full  <= req_valid && !any_free;
         grant_q.cls   <= pg_class_e'(req_class);
         idx_q         <= take ? low_idx : '0;
         err_q         <= free_valid && !free_good;
      end
   end

   assign grant_valid = grant_q.valid;
   assign grant_full  = grant_q.full;
   assign grant_idx   = idx_q;
   assign grant_class = grant_q.cls;
   assign free_err    = err_q;
endmodule

// File: rtl/pgid_alloc_chk.sv
module pgid_alloc_chk #(
   parameter int TABLE_DEPTH = 1024,
   parameter int RSVD_COUNT  = 72,
   parameter int GAGG_BASE   = 512,
   parameter int GAGG_LEN    = 64,
   localparam int IDX_W      = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             free_valid,
   input logic             grant_valid,
   input logic             grant_full,
   input logic [IDX_W-1:0] grant_idx,
   input logic             free_err
);
   assert_grant_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> $past(req_valid));

   assert_no_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !grant_full) |-> (int'(grant_idx) >= RSVD_COUNT));

   assert_no_held_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !grant_full) |->
         !(int'(grant_idx) >= GAGG_BASE && int'(grant_idx) < GAGG_BASE + GAGG_LEN));

   assert_full_in_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grant_full |-> (grant_valid && grant_idx == '0));

   assert_err_after_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      free_err |-> $past(free_valid));
endmodule

bind pgid_alloc pgid_alloc_chk #(
   .TABLE_DEPTH(TABLE_DEPTH), .RSVD_COUNT(RSVD_COUNT),
   .GAGG_BASE(GAGG_BASE), .GAGG_LEN(GAGG_LEN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .free_valid(free_valid),
   .grant_valid(grant_valid), .grant_full(grant_full), .grant_idx(grant_idx),
   .free_err(free_err)
);

// File: tb/pgid_alloc_bench.sv
module pgid_alloc_bench;
   localparam int DEPTH = 32;
   localparam int RSVD  = 8;
   localparam int GB    = 16;
   localparam int GL    = 4;
   localparam int IW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_class = 2'd0;
   logic          free_valid = 1'b0;
   logic [IW-1:0] free_idx = '0;
   logic          grant_valid, grant_full, free_err;
   logic [IW-1:0] grant_idx;
   logic [1:0]    grant_class;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   bit  m_used [DEPTH];

   always #10 clk = ~clk;

   pgid_alloc #(.TABLE_DEPTH(DEPTH), .RSVD_COUNT(RSVD), .GAGG_BASE(GB), .GAGG_LEN(GL))
   u_pgid_alloc (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
      .free_valid(free_valid), .free_idx(free_idx), .grant_valid(grant_valid),
      .grant_full(grant_full), .grant_idx(grant_idx), .grant_class(grant_class),
      .free_err(free_err)
   );

   function automatic bit allocatable(int i);
      return i >= RSVD && i < DEPTH && !(i >= GB && i < GB + GL);
   endfunction

   function automatic int lowest_free();
      for (int i = 0; i < DEPTH; i++)
         if (allocatable(i) && !m_used[i]) return i;
      return -1;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One cycle: drive at negedge, sample after the next edge at the following negedge.
   task automatic step(input bit rq, input int cl, input bit fv, input int fi, input string tag);
      int  e_idx;
      bit  e_full, f_good;
      e_idx  = lowest_free();
      e_full = (e_idx < 0);
      f_good = fv && allocatable(fi) && m_used[fi];
      req_valid  = rq;
      req_class  = 2'(cl);
      free_valid = fv;
      free_idx   = IW'(fi);
      @(posedge clk);
      if (rq && !e_full) m_used[e_idx] = 1'b1;
      if (f_good) m_used[fi] = 1'b0;
      @(negedge clk);
      req_valid  = 1'b0;
      free_valid = 1'b0;
      check(grant_valid == rq, {tag, " R2 grant_valid"}, int'(grant_valid), int'(rq));
      if (rq) begin
         check(grant_full == e_full, {tag, " R6 grant_full"}, int'(grant_full), int'(e_full));
         check(int'(grant_idx) == (e_full ? 0 : e_idx), {tag, " R3 grant_idx"},
               int'(grant_idx), e_full ? 0 : e_idx);
         check(int'(grant_class) == cl, {tag, " R10 grant_class"}, int'(grant_class), cl);
         if (!e_full) begin
            check(int'(grant_idx) >= RSVD, {tag, " R4 reserved"}, int'(grant_idx), RSVD);
            check(!(int'(grant_idx) >= GB && int'(grant_idx) < GB + GL), {tag, " R5 window"},
                  int'(grant_idx), GB);
         end
      end
      check(free_err == (fv && !f_good), {tag, " R8 free_err"}, int'(free_err),
            int'(fv && !f_good));
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) m_used[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(!grant_valid && !grant_full && !free_err, "R1 reset outputs", 
            int'({grant_valid, grant_full, free_err}), 0);
      step(1'b0, 0, 1'b0, 0, "R2 idle");
      step(1'b1, 0, 1'b0, 0, "R1 first grant");
      check(m_used[RSVD], "R1 first index", 0, RSVD);
      // fill the pool, rotating classes (R3, R4, R5, R10)
      for (int k = 0; k < 19; k++) step(1'b1, k % 3, 1'b0, 0, "R3 fill");
      step(1'b1, 1, 1'b0, 0, "R6 full");
      step(1'b1, 2, 1'b0, 0, "R6 full again");
      // sweep frees of every reserved and held-back index (R8)
      for (int i = 0; i < RSVD; i++) step(1'b0, 0, 1'b1, i, "R8 reserved free");
      for (int i = GB; i < GB + GL; i++) step(1'b0, 0, 1'b1, i, "R8 window free");
      step(1'b1, 0, 1'b0, 0, "R8 still full");
      // simultaneous request and free while full (R9)
      step(1'b1, 1, 1'b1, 12, "R9 same cycle");
      step(1'b1, 1, 1'b0, 0, "R9 next cycle");
      // scattered frees, then re-allocation in ascending order (R7)
      step(1'b0, 0, 1'b1, 30, "R7 free");
      step(1'b0, 0, 1'b1, 10, "R7 free");
      step(1'b0, 0, 1'b1, 25, "R7 free");
      step(1'b0, 0, 1'b1, 25, "R8 double free");
      step(1'b1, 2, 1'b0, 0, "R7 realloc");
      step(1'b1, 0, 1'b1, 21, "R9 alloc+free");
      step(1'b1, 1, 1'b0, 0, "R7 realloc");
      step(1'b1, 2, 1'b0, 0, "R7 realloc");
      step(1'b1, 0, 1'b0, 0, "R6 full end");
      // drain everything then free an unused entry (R8)
      for (int i = 0; i < DEPTH; i++)
         if (allocatable(i)) step(1'b0, 0, 1'b1, i, "R7 drain");
      step(1'b0, 0, 1'b1, 9, "R8 unused free");
      step(1'b1, 0, 1'b0, 0, "R7 after drain");
      step(1'b0, 0, 1'b0, 0, "R2 quiet");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule